// File: doc/BRIEF.md
# Ethernet MAC Control and Local Reset Sequencer

This block holds the single control word of an Ethernet MAC and turns writes to it into run, stop and reset commands for the rest of the MAC. It sits on a simple 32-bit register bus. It has three control fields: a transmit retime flag, a MAC enable flag and a self-clearing local reset flag. From these it drives receive and transmit run levels, a reset for the DMA, descriptor and FIFO control logic, and a local reset for the whole MAC.

When software clears the enable flag while a frame is leaving the transmitter, the block does not cut the frame off. It holds an abort request until the transmitter reports that it has closed the frame with a corrupted CRC. A timeout ends the abort if that report never comes. During the abort, status strobes from the transmitter are blocked, so the aborted frame never updates its descriptor. A local reset works differently: it is abrupt, lasts a fixed number of cycles, and clears the control word.

The block also contains the transmit-side output stage for the MII pins. It registers the nibble, the enable and the error bit on the rising transmit clock. When retiming is on, it moves them to the following falling edge, which gives half a transmit clock of extra hold time.

Top module: `emac_ctl_top`

## Requirements
- R1: The control word is at byte offset 0x840 (parameter `REG_OFFSET`). A read there returns the retime flag in bit 25, the enable state in bit 1 and the local-reset-busy state in bit 0, with every other bit zero. A read anywhere else, and any write cycle, returns zero on `bus_rdata`. Writes to any other offset change nothing. After reset the word reads zero.
- R2: A write with bit 1 = 1 and bit 0 = 0, made while the MAC is neither aborting nor in local reset, raises `rx_run` and `tx_run` and lowers `dma_rst` on the following cycle.
- R3: A write with bit 1 = 0 and bit 0 = 0, made while running with `tx_busy` low, lowers `rx_run` and `tx_run` and raises `dma_rst` on the following cycle.
- R4: The same write made with `tx_busy` high lowers `rx_run` and raises `dma_rst` on the following cycle. `abort_req` and `tx_run` then stay high until the cycle after an `abort_done` pulse.
- R5: If `abort_done` never arrives, `abort_req` stays high for exactly `ABORT_TMO` cycles and then falls.
- R6: `tx_stat_o` follows `tx_stat_i` only while the MAC is running. It stays low while aborting, while disabled and during local reset.
- R7: A write with bit 0 = 1 starts a local reset. `mac_lrst` is high for exactly `LRST_CYCLES` (16) cycles, starting on the next cycle. While it is high, bit 0 reads 1. The enable and retime flags are cleared. Any abort ends at once.
- R8: A write with both bit 0 and bit 1 set performs the local reset and leaves the MAC disabled.
- R9: A write with bit 0 = 1 during a local reset restarts the full `LRST_CYCLES` count from that write.
- R10: During a local reset, writes with bit 0 = 0 are ignored, including their enable and retime bits.
- R11: During an abort, a write of bit 1 = 1 does not re-enable the MAC. Its bit 25 still updates the retime flag.
- R12: With the retime flag at 0, `mii_txd_o`, `mii_txen_o` and `mii_txer_o` show the inputs captured at the latest rising `tx_clk` edge.
- R13: With the retime flag at 1, the MII outputs change on the falling `tx_clk` edge, half a period after capture. A change of the flag takes effect after `SYNC_STAGES` rising `tx_clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tx_busy | input | 1 | Transmitter has a frame in progress |
| abort_done | input | 1 | One-cycle pulse: bad-CRC tail sent |
| tx_stat_i | input | 1 | Transmit status-update strobe from the transmitter |
| tx_stat_o | output | 1 | Gated status-update strobe to descriptor logic |
| rx_run | output | 1 | Receive allowed |
| tx_run | output | 1 | Transmit allowed (includes the abort tail) |
| abort_req | output | 1 | Request to close the current frame with a bad CRC |
| dma_rst | output | 1 | Reset for DMA, descriptor and FIFO control |
| mac_lrst | output | 1 | MAC-local reset |
| tx_clk | input | 1 | MII transmit clock |
| mii_txd_i | input | 4 | Transmit nibble from the MAC |
| mii_txen_i | input | 1 | Transmit enable from the MAC |
| mii_txer_i | input | 1 | Transmit error from the MAC |
| mii_txd_o | output | 4 | Transmit nibble to the PHY |
| mii_txen_o | output | 1 | Transmit enable to the PHY |
| mii_txer_o | output | 1 | Transmit error to the PHY |

## Verification
A wrong sequencer state shows at the ports in the very next cycle. It appears as a run level, `abort_req`, `dma_rst` or `mac_lrst` that disagrees with the last accepted write, and as the enable and busy bits of a read. A counter that is off by one moves the falling edge of `mac_lrst` or `abort_req` by a cycle, so the length of each window is checked exactly. A wrong retime selection shows within half a transmit clock, as MII outputs that change on the wrong edge after the synchronizer delay.

// File: rtl/emac_ctl_pkg.sv
`timescale 1ns/1ps
package emac_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ABORT = 2'd2,
    ST_LRST  = 2'd3
  } emac_st_e;

  localparam int BIT_RETIME = 25;
  localparam int BIT_EN     = 1;
  localparam int BIT_RST    = 0;
  localparam int DATA_W     = 32;

endpackage

// File: rtl/emac_rst_sync.sv
`timescale 1ns/1ps
module emac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= (chain_q << 1) | STAGES'(1);
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/emac_ctl_regs.sv
`timescale 1ns/1ps
module emac_ctl_regs
  import emac_ctl_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h840
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  emac_st_e          state,
  output logic              wr_go,
  output logic              wr_enable,
  output logic              wr_lrst,
  output logic              retime
);

  logic addr_hit;
  logic rd_hit;
  logic in_lrst;
  logic retime_q, retime_d, retime_ce;
  logic wdata_unused;

  assign addr_hit  = bus_sel && (bus_addr == REG_OFFSET);
  assign wr_go     = addr_hit && bus_wr;
  assign rd_hit    = addr_hit && !bus_wr;
  assign wr_enable = bus_wdata[BIT_EN];
  assign wr_lrst   = bus_wdata[BIT_RST];
  assign in_lrst   = (state == ST_LRST);

  assign wdata_unused = ^{bus_wdata[DATA_W-1:BIT_RETIME+1],
                          bus_wdata[BIT_RETIME-1:BIT_EN+1]};

  // A reset write clears the flag; other writes load it unless a
  // local reset is holding the word.
  always_comb begin
    retime_ce = 1'b0;
    retime_d  = retime_q;
    if (wr_go && wr_lrst) begin
      retime_ce = 1'b1;
      retime_d  = 1'b0;
    end else if (wr_go && !in_lrst) begin
      retime_ce = 1'b1;
      retime_d  = bus_wdata[BIT_RETIME];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         retime_q <= 1'b0;
    else if (retime_ce) retime_q <= retime_d;
  end

  assign retime = retime_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      bus_rdata[BIT_RETIME] = retime_q;
      bus_rdata[BIT_EN]     = (state == ST_RUN);
      bus_rdata[BIT_RST]    = in_lrst;
    end
  end

endmodule

// File: rtl/emac_ctl_seq.sv
`timescale 1ns/1ps
module emac_ctl_seq
  import emac_ctl_pkg::*;
#(
  parameter int LRST_CYCLES = 16,
  parameter int ABORT_TMO   = 256
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_go,
  input  logic     wr_enable,
  input  logic     wr_lrst,
  input  logic     tx_busy,
  input  logic     abort_done,
  output emac_st_e state
);

  localparam int LCW = (LRST_CYCLES > 1) ? $clog2(LRST_CYCLES) : 1;
  localparam int TCW = (ABORT_TMO > 1)   ? $clog2(ABORT_TMO)   : 1;
  localparam logic [LCW-1:0] LRST_LAST = LCW'(LRST_CYCLES - 1);
  localparam logic [TCW-1:0] TMO_LAST  = TCW'(ABORT_TMO - 1);

  emac_st_e       st_q, st_d;
  logic [LCW-1:0] lcnt_q, lcnt_d;
  logic [TCW-1:0] tcnt_q, tcnt_d;
  logic           lcnt_ce, tcnt_ce;

  always_comb begin
    st_d    = st_q;
    lcnt_d  = lcnt_q;
    tcnt_d  = tcnt_q;
    lcnt_ce = 1'b0;
    tcnt_ce = 1'b0;
    if (wr_go && wr_lrst) begin
      // local reset wins over everything, restarts if already running
      st_d    = ST_LRST;
      lcnt_d  = LRST_LAST;
      lcnt_ce = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_go && wr_enable) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (wr_go && !wr_enable) begin
            if (tx_busy) begin
              st_d    = ST_ABORT;
              tcnt_d  = '0;
              tcnt_ce = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ABORT: begin
          if (abort_done || (tcnt_q == TMO_LAST)) begin
            st_d = ST_IDLE;
          end else begin
            tcnt_d  = tcnt_q + 1'b1;
            tcnt_ce = 1'b1;
          end
        end
        ST_LRST: begin
          if (lcnt_q == '0) begin
            st_d = ST_IDLE;
          end else begin
            lcnt_d  = lcnt_q - 1'b1;
            lcnt_ce = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lcnt_q <= '0;
    else if (lcnt_ce) lcnt_q <= lcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tcnt_q <= '0;
    else if (tcnt_ce) tcnt_q <= tcnt_d;
  end

  assign state = st_q;

endmodule

// File: rtl/emac_tx_retime.sv
`timescale 1ns/1ps
module emac_tx_retime #(
  parameter int LANES       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tx_clk,
  input  logic             rst_n,
  input  logic             retime_async,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);

  logic [SYNC_STAGES-1:0] sel_sync_q;
  logic                   sel;

  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) sel_sync_q <= '0;
    else        sel_sync_q <= (sel_sync_q << 1) | SYNC_STAGES'(retime_async);
  end

  assign sel = sel_sync_q[SYNC_STAGES-1];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic rise_q;
    logic fall_q;

    always_ff @(posedge tx_clk or negedge rst_n) begin
      if (!rst_n) rise_q <= 1'b0;
      else        rise_q <= din[i];
    end

    always_ff @(negedge tx_clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= rise_q;
    end

    assign dout[i] = sel ? fall_q : rise_q;
  end

endmodule

// File: rtl/emac_ctl_top.sv
`timescale 1ns/1ps
module emac_ctl_top
  import emac_ctl_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 'h840,
  parameter int                LRST_CYCLES = 16,
  parameter int                ABORT_TMO   = 256,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tx_busy,
  input  logic              abort_done,
  input  logic              tx_stat_i,
  output logic              tx_stat_o,
  output logic              rx_run,
  output logic              tx_run,
  output logic              abort_req,
  output logic              dma_rst,
  output logic              mac_lrst,
  input  logic              tx_clk,
  input  logic [3:0]        mii_txd_i,
  input  logic              mii_txen_i,
  input  logic              mii_txer_i,
  output logic [3:0]        mii_txd_o,
  output logic              mii_txen_o,
  output logic              mii_txer_o
);

  localparam int LANES = 6;

  logic     core_rst_n, tx_rst_n;
  logic     wr_go, wr_enable, wr_lrst, retime;
  emac_st_e state;
  logic [LANES-1:0] lane_in, lane_out;

  emac_rst_sync #(.STAGES(RST_STAGES)) u_rs_core (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(core_rst_n)
  );

  emac_rst_sync #(.STAGES(RST_STAGES)) u_rs_tx (
    .clk(tx_clk), .rst_n_in(rst_n), .rst_n_out(tx_rst_n)
  );

  emac_ctl_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .state(state), .wr_go(wr_go), .wr_enable(wr_enable),
    .wr_lrst(wr_lrst), .retime(retime)
  );

  emac_ctl_seq #(.LRST_CYCLES(LRST_CYCLES), .ABORT_TMO(ABORT_TMO)) u_seq (
    .clk(clk), .rst_n(core_rst_n),
    .wr_go(wr_go), .wr_enable(wr_enable), .wr_lrst(wr_lrst),
    .tx_busy(tx_busy), .abort_done(abort_done), .state(state)
  );

  assign rx_run    = (state == ST_RUN);
  assign tx_run    = (state == ST_RUN) || (state == ST_ABORT);
  assign abort_req = (state == ST_ABORT);
  assign dma_rst   = (state != ST_RUN);
  assign mac_lrst  = (state == ST_LRST);
  assign tx_stat_o = tx_stat_i && (state == ST_RUN);

  assign lane_in = {mii_txd_i, mii_txen_i, mii_txer_i};

  emac_tx_retime #(.LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_retime (
    .tx_clk(tx_clk), .rst_n(tx_rst_n), .retime_async(retime),
    .din(lane_in), .dout(lane_out)
  );

  assign mii_txd_o  = lane_out[5:2];
  assign mii_txen_o = lane_out[1];
  assign mii_txer_o = lane_out[0];

endmodule

// File: rtl/emac_ctl_chk.sv
`timescale 1ns/1ps
module emac_ctl_chk #(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 'h840,
  parameter int                LRST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_en,
  input logic              wd_rst,
  input logic [31:0]       bus_rdata,
  input logic              abort_done,
  input logic              tx_stat_o,
  input logic              rx_run,
  input logic              tx_run,
  input logic              abort_req,
  input logic              mac_lrst
);

  localparam int CW = $clog2(LRST_CYCLES + 1) + 1;

  logic          hit_wr, hit_rd, rst_wr;
  logic [CW-1:0] lrun_q;

  assign hit_wr = bus_sel && bus_wr && (bus_addr == REG_OFFSET);
  assign hit_rd = bus_sel && !bus_wr && (bus_addr == REG_OFFSET);
  assign rst_wr = hit_wr && wd_rst;

  // cycles spent in local reset since the latest reset write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lrun_q <= '0;
    else if (rst_wr)                     lrun_q <= '0;
    else if (mac_lrst && !(&lrun_q))     lrun_q <= lrun_q + 1'b1;
  end

  assert_rdata_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_rd |-> (bus_rdata == 32'h0));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[31:26] == 6'h0) && (bus_rdata[24:2] == 23'h0));

  assert_enable_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && wd_en && !wd_rst && !mac_lrst && !abort_req) |=> rx_run);

  assert_abort_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> $past(rx_run));

  assert_abort_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && abort_done) |=> !abort_req);

  assert_stat_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run |-> !tx_stat_o);

  assert_lrst_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mac_lrst |-> (!tx_run && !abort_req && !bus_rdata[1]));

  assert_lrst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mac_lrst) |-> (lrun_q == CW'(LRST_CYCLES)));

  assert_rst_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (mac_lrst && !rx_run));

endmodule

bind emac_ctl_top emac_ctl_chk #(
  .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .LRST_CYCLES(LRST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wd_en(bus_wdata[1]), .wd_rst(bus_wdata[0]),
  .bus_rdata(bus_rdata), .abort_done(abort_done), .tx_stat_o(tx_stat_o),
  .rx_run(rx_run), .tx_run(tx_run), .abort_req(abort_req), .mac_lrst(mac_lrst)
);

// File: tb/sim_emac_ctl_top.sv
`timescale 1ns/1ps
module sim_emac_ctl_top;

  localparam int TMO  = 256;
  localparam int LRST = 16;
  localparam logic [11:0] OFS = 12'h840;
  localparam int M_IDLE = 0, M_RUN = 1, M_ABORT = 2, M_LRST = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_busy = 0, abort_done = 0, tx_stat_i = 0;
  logic        tx_stat_o, rx_run, tx_run, abort_req, dma_rst, mac_lrst;
  logic [3:0]  mii_txd_i = '0;
  logic        mii_txen_i = 0, mii_txer_i = 0;
  logic [3:0]  mii_txd_o;
  logic        mii_txen_o, mii_txer_o;

  int    n_chk = 0, n_fail = 0;
  string phase = "R1 reset";
  bit    done = 0;

  always #2.5 clk = ~clk;

  emac_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_busy(tx_busy), .abort_done(abort_done), .tx_stat_i(tx_stat_i),
    .tx_stat_o(tx_stat_o), .rx_run(rx_run), .tx_run(tx_run),
    .abort_req(abort_req), .dma_rst(dma_rst), .mac_lrst(mac_lrst),
    .tx_clk(clk), .mii_txd_i(mii_txd_i), .mii_txen_i(mii_txen_i),
    .mii_txer_i(mii_txer_i), .mii_txd_o(mii_txd_o), .mii_txen_o(mii_txen_o),
    .mii_txer_o(mii_txer_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL [%s] %s actual=%h expected=%h t=%0t", phase, tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_st, m_left, m_age, m_rs;
  bit   m_ret, m_s1, m_s2;
  logic [5:0] m_p, m_prev;

  task automatic model_clear();
    m_st = M_IDLE; m_left = 0; m_age = 0; m_ret = 0;
    m_s1 = 0; m_s2 = 0; m_p = '0; m_prev = '0;
  endtask

  task automatic model_edge();
    bit wr;
    int old_st;
    if (!rst_n) begin m_rs = 0; model_clear(); return; end
    if (m_rs < 2) begin m_rs++; model_clear(); return; end
    // transmit side uses the flag value from before this edge
    m_prev = m_p;
    m_p    = {mii_txd_i, mii_txen_i, mii_txer_i};
    m_s2   = m_s1;
    m_s1   = m_ret;
    wr     = bus_sel && bus_wr && (bus_addr == OFS);
    old_st = m_st;
    if (wr && bus_wdata[0]) begin
      m_st = M_LRST; m_left = LRST; m_ret = 0;
      return;
    end
    if (wr && old_st != M_LRST) m_ret = bus_wdata[25];
    case (old_st)
      M_IDLE:  if (wr && bus_wdata[1]) m_st = M_RUN;
      M_RUN:   if (wr && !bus_wdata[1]) begin
                 if (tx_busy) begin m_st = M_ABORT; m_age = 0; end
                 else m_st = M_IDLE;
               end
      M_ABORT: if (abort_done) m_st = M_IDLE;
               else begin m_age++; if (m_age == TMO) m_st = M_IDLE; end
      default: begin m_left--; if (m_left == 0) m_st = M_IDLE; end
    endcase
  endtask

  always @(posedge clk) begin
    logic [31:0] exp_rd;
    model_edge();
    #2;
    if (m_rs == 2 && !done) begin
      exp_rd = '0;
      if (bus_sel && !bus_wr && bus_addr == OFS) begin
        exp_rd[25] = m_ret;
        exp_rd[1]  = (m_st == M_RUN);
        exp_rd[0]  = (m_st == M_LRST);
      end
      chk("rdata R1", bus_rdata, exp_rd);
      chk("rx_run R2 R3", {31'b0, rx_run}, {31'b0, m_st == M_RUN});
      chk("tx_run R4 R5", {31'b0, tx_run}, {31'b0, m_st == M_RUN || m_st == M_ABORT});
      chk("abort_req R4 R5 R11", {31'b0, abort_req}, {31'b0, m_st == M_ABORT});
      chk("dma_rst R3", {31'b0, dma_rst}, {31'b0, m_st != M_RUN});
      chk("mac_lrst R7 R9 R10", {31'b0, mac_lrst}, {31'b0, m_st == M_LRST});
      chk("tx_stat_o R6", {31'b0, tx_stat_o}, {31'b0, tx_stat_i && m_st == M_RUN});
      chk("mii_early R12 R13", {26'b0, mii_txd_o, mii_txen_o, mii_txer_o},
          {26'b0, (m_s2 ? m_prev : m_p)});
    end
    #2;
    if (m_rs == 2 && !done)
      chk("mii_late R13", {26'b0, mii_txd_o, mii_txen_o, mii_txer_o}, {26'b0, m_p});
  end

  // random transmit lanes, changed away from the edges
  always @(posedge clk) begin
    #1;
    {mii_txd_i, mii_txen_i, mii_txer_i} = 6'($urandom);
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; abort_done = 0; tx_stat_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic wr32(logic [11:0] a, logic [31:0] d);
    tick(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd32(logic [11:0] a);
    tick(); bus_sel = 1; bus_wr = 0; bus_addr = a;
  endtask

  task automatic stat_pulse();
    tick(); tx_stat_i = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL [%s] watchdog actual=hung expected=finished", phase);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);

    phase = "R1 reset value and decode";
    rd32(OFS); rd32(12'h844); wr32(12'h844, 32'h0200_0002); idle(2); rd32(OFS);

    phase = "R2 enable"; wr32(OFS, 32'h2); idle(2); rd32(OFS);
    phase = "R6 status passes while running"; stat_pulse(); stat_pulse(); idle(1);

    phase = "R12 retime off"; idle(8);
    phase = "R13 retime on"; wr32(OFS, 32'h0200_0002); idle(10); rd32(OFS);
    phase = "R13 retime back off"; wr32(OFS, 32'h2); idle(6);

    phase = "R3 disable idle"; wr32(OFS, 32'h0); idle(2); rd32(OFS);

    phase = "R4 abort with done";
    wr32(OFS, 32'h2); idle(1); tx_busy = 1; wr32(OFS, 32'h0); idle(3);
    phase = "R6 status blocked in abort"; stat_pulse(); idle(2);
    phase = "R4 abort done"; tick(); abort_done = 1; idle(2); tx_busy = 0;
    phase = "R6 status blocked idle"; stat_pulse(); idle(2);

    phase = "R11 enable ignored in abort";
    wr32(OFS, 32'h2); tx_busy = 1; wr32(OFS, 32'h0); idle(2);
    wr32(OFS, 32'h0200_0002); rd32(OFS); idle(3);
    tick(); abort_done = 1; idle(2); tx_busy = 0; rd32(OFS);
    wr32(OFS, 32'h0); idle(3);

    phase = "R5 abort timeout";
    wr32(OFS, 32'h2); tx_busy = 1; wr32(OFS, 32'h0); idle(TMO + 10);
    tx_busy = 0; tick(); abort_done = 1; idle(2);

    phase = "R7 local reset";
    wr32(OFS, 32'h0200_0002); idle(4); wr32(OFS, 32'h1); rd32(OFS);
    idle(8); rd32(OFS); idle(12); rd32(OFS);

    phase = "R7 local reset cuts abort";
    wr32(OFS, 32'h2); tx_busy = 1; wr32(OFS, 32'h0); idle(3);
    wr32(OFS, 32'h1); idle(20); tx_busy = 0;

    phase = "R8 reset wins over enable"; wr32(OFS, 32'h3); idle(20); rd32(OFS);

    phase = "R9 restart"; wr32(OFS, 32'h1); idle(8); wr32(OFS, 32'h1); idle(22);

    phase = "R10 writes ignored in reset";
    wr32(OFS, 32'h1); idle(3); wr32(OFS, 32'h0200_0002); rd32(OFS);
    idle(20); rd32(OFS);
    phase = "R2 enable after reset"; wr32(OFS, 32'h2); idle(3); rd32(OFS);
    phase = "R6 status after reset"; stat_pulse(); idle(4);

    done = 1;
    #10;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule